// File: doc/BRIEF.md
# Package Idle State Resolver

This block works out the idle state of a whole package from the idle states of its cores. Every core reports a 2-bit state code. The package can only go as deep as its shallowest core. The platform can veto any low-power state, and a 2-bit depth limit caps how deep the package may go. The resolved state is worked out again on every cycle.

When the resolved state is C1 and the enhanced option is enabled, a two-step operating-point sequencer moves the package to its low point. It first requests the low frequency ratio and waits for the clock generator to acknowledge it. Only then does it request the low voltage identifier and wait for the regulator to acknowledge. Leaving the low point runs the same steps in reverse. The voltage is restored to the value saved at entry and acknowledged, and after that the ratio is restored. The package-state output is only updated while the sequencer is idle and already sits at the operating point that the new state needs. No notification is raised on entry to C1.

Outside the low point, the ratio and voltage requests follow the nominal inputs. The clock generator and the regulator sit outside the block. They are represented only by their acknowledge inputs.

Top module: `pkg_idle_resolver`

## Requirements
- R1: After reset, `pkg_state` is C0 (2'b00) and `busy` is low.
- R2: State codes are C0=2'b00, C1=2'b01, C3=2'b10 and C6=2'b11, with core i on bits [2i+1:2i] of `core_states`. The package resolves to C0 whenever any core is in C0 or `plat_grant` is low.
- R3: Otherwise, the package resolves to the shallowest of the core states (the numerically smallest code).
- R4: `depth_limit` caps the resolved state: 2'b00 caps it at C1, 2'b01 caps it at C3, and 2'b10 or 2'b11 caps it at C6.
- R5: When the resolved state is C1 and `c1e_en` is high, `ratio_req` moves to LOW_RATIO first. `vid_req` moves to LOW_VID only after `ratio_ack` has been seen while the ratio step is pending.
- R6: On leaving the low point, `vid_req` returns to the value saved at entry while `ratio_req` stays at LOW_RATIO. `ratio_req` returns to its saved value only after `vid_ack`. An acknowledge for the wrong step is ignored.
- R7: `busy` is high while a sequencer step is waiting for its acknowledge. `pkg_state` does not change while `busy` is high. On entry to C1 with the low point, `pkg_state` keeps its old value until both steps have completed.
- R8: With `c1e_en` low, a C1 resolution is shown on `pkg_state` one cycle after the inputs settle, and no operating-point step takes place.
- R9: In any settled state other than enhanced C1, `ratio_req` and `vid_req` equal `nom_ratio` and `nom_vid` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_states | input | 2*NCORES | Per-core idle state codes |
| plat_grant | input | 1 | Platform permits a low-power package state |
| depth_limit | input | 2 | Package depth cap selector |
| c1e_en | input | 1 | Enables the low operating point in C1 |
| nom_ratio | input | RATIO_W | Nominal frequency ratio |
| nom_vid | input | VID_W | Nominal voltage identifier |
| ratio_ack | input | 1 | Clock generator has reached the requested ratio |
| vid_ack | input | 1 | Regulator has reached the requested voltage |
| pkg_state | output | 2 | Committed package idle state |
| ratio_req | output | RATIO_W | Requested frequency ratio |
| vid_req | output | VID_W | Requested voltage identifier |
| busy | output | 1 | Operating-point step in progress |

## Verification
The bench holds both acknowledges low and releases them one at a time. This shows that the voltage never drops before the ratio has settled. A design with the order swapped would show the low voltage at the nominal ratio. On exit, the bench sends a ratio acknowledge early, while the voltage step is still pending. A design that takes any acknowledge would then raise the ratio before the voltage has been restored. The bench also checks that the reported state stays at C0 for the whole ramp, which catches a design that commits C1 before the low point is reached. Further checks cover the depth cap with every core in C6 and every limit code, a platform veto, and C1 with the enhanced option off. A design that decodes the limit wrongly, ignores the veto, or steps the operating point without the enable would each fail one of these.

// File: rtl/pkg_idle_pkg.sv
`timescale 1ns/1ps
package pkg_idle_pkg;
  typedef enum logic [1:0] {
    CS_C0 = 2'b00,
    CS_C1 = 2'b01,
    CS_C3 = 2'b10,
    CS_C6 = 2'b11
  } cstate_e;

  typedef enum logic [2:0] {
    OP_HIGH        = 3'd0,
    OP_DROP_RATIO  = 3'd1,
    OP_DROP_VID    = 3'd2,
    OP_LOW         = 3'd3,
    OP_RAISE_VID   = 3'd4,
    OP_RAISE_RATIO = 3'd5
  } op_state_e;
endpackage

// File: rtl/pkg_core_min.sv
`timescale 1ns/1ps
module pkg_core_min
  import pkg_idle_pkg::*;
#(
  parameter int NCORES = 4
) (
  input  logic [2*NCORES-1:0] core_states,
  output cstate_e             shallowest
);
  logic [1:0] chain [NCORES+1];

  assign chain[0] = 2'b11;

  for (genvar g = 0; g < NCORES; g++) begin : g_min
    logic [1:0] st;
    assign st         = core_states[2*g +: 2];
    assign chain[g+1] = (st < chain[g]) ? st : chain[g];
  end

  assign shallowest = cstate_e'(chain[NCORES]);
endmodule

// File: rtl/pkg_depth_cap.sv
`timescale 1ns/1ps
module pkg_depth_cap
  import pkg_idle_pkg::*;
(
  input  cstate_e    shallowest,
  input  logic       plat_grant,
  input  logic [1:0] depth_limit,
  output cstate_e    target
);
  cstate_e cap;

  always_comb begin
    if (depth_limit[1])      cap = CS_C6;
    else if (depth_limit[0]) cap = CS_C3;
    else                     cap = CS_C1;
  end

  always_comb begin
    if (shallowest == CS_C0 || !plat_grant) target = CS_C0;
    else if (shallowest > cap)              target = cap;
    else                                    target = shallowest;
  end
endmodule

// File: rtl/pkg_opp_seq.sv
`timescale 1ns/1ps
module pkg_opp_seq
  import pkg_idle_pkg::*;
#(
  parameter int              RATIO_W   = 6,
  parameter int              VID_W     = 8,
  parameter logic [RATIO_W-1:0] LOW_RATIO = 6'd8,
  parameter logic [VID_W-1:0]   LOW_VID   = 8'h20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               want_low,
  input  logic [RATIO_W-1:0] nom_ratio,
  input  logic [VID_W-1:0]   nom_vid,
  input  logic               ratio_ack,
  input  logic               vid_ack,
  output logic [RATIO_W-1:0] ratio_req,
  output logic [VID_W-1:0]   vid_req,
  output logic               busy,
  output logic               at_low
);
  op_state_e          state_q, state_d;
  logic [RATIO_W-1:0] ratio_q, ratio_d, saved_ratio_q;
  logic [VID_W-1:0]   vid_q, vid_d, saved_vid_q;
  logic               save_en;

  always_comb begin
    state_d = state_q;
    ratio_d = ratio_q;
    vid_d   = vid_q;
    save_en = 1'b0;
    case (state_q)
      OP_HIGH: begin
        if (want_low) begin
          state_d = OP_DROP_RATIO;
          ratio_d = LOW_RATIO;
          save_en = 1'b1;
        end else begin
          ratio_d = nom_ratio;
          vid_d   = nom_vid;
        end
      end
      OP_DROP_RATIO: begin
        if (ratio_ack) begin
          state_d = OP_DROP_VID;
          vid_d   = LOW_VID;
        end
      end
      OP_DROP_VID: begin
        if (vid_ack) state_d = OP_LOW;
      end
      OP_LOW: begin
        if (!want_low) begin
          state_d = OP_RAISE_VID;
          vid_d   = saved_vid_q;
        end
      end
      OP_RAISE_VID: begin
        if (vid_ack) begin
          state_d = OP_RAISE_RATIO;
          ratio_d = saved_ratio_q;
        end
      end
      OP_RAISE_RATIO: begin
        if (ratio_ack) state_d = OP_HIGH;
      end
      default: state_d = OP_HIGH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= OP_HIGH;
      ratio_q <= '0;
      vid_q   <= '0;
    end else begin
      state_q <= state_d;
      ratio_q <= ratio_d;
      vid_q   <= vid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      saved_ratio_q <= '0;
      saved_vid_q   <= '0;
    end else if (save_en) begin
      saved_ratio_q <= ratio_q;
      saved_vid_q   <= vid_q;
    end
  end

  assign ratio_req = ratio_q;
  assign vid_req   = vid_q;
  assign at_low    = (state_q == OP_LOW);
  assign busy      = (state_q != OP_HIGH) && (state_q != OP_LOW);

  // R5: the voltage step only follows a completed ratio step
  a_r5_vid_after_ratio: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == OP_DROP_RATIO && !ratio_ack) |=> (vid_q == $past(vid_q)));

  a_r5_low_point: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == OP_LOW) |-> (ratio_q == LOW_RATIO && vid_q == LOW_VID));

  // R6: the ratio is raised only once the voltage is back at its saved value
  a_r6_ratio_after_vid: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == OP_RAISE_RATIO) |-> (vid_q == saved_vid_q));

  a_r6_hold_ratio: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == OP_RAISE_VID) |-> (ratio_q == LOW_RATIO));
endmodule

// File: rtl/pkg_idle_resolver.sv
`timescale 1ns/1ps
module pkg_idle_resolver
  import pkg_idle_pkg::*;
#(
  parameter int                 NCORES    = 4,
  parameter int                 RATIO_W   = 6,
  parameter int                 VID_W     = 8,
  parameter logic [RATIO_W-1:0] LOW_RATIO = 6'd8,
  parameter logic [VID_W-1:0]   LOW_VID   = 8'h20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*NCORES-1:0]   core_states,
  input  logic                  plat_grant,
  input  logic [1:0]            depth_limit,
  input  logic                  c1e_en,
  input  logic [RATIO_W-1:0]    nom_ratio,
  input  logic [VID_W-1:0]      nom_vid,
  input  logic                  ratio_ack,
  input  logic                  vid_ack,
  output logic [1:0]            pkg_state,
  output logic [RATIO_W-1:0]    ratio_req,
  output logic [VID_W-1:0]      vid_req,
  output logic                  busy
);
  cstate_e shallowest, target, state_q, state_d;
  logic    want_low, at_low, commit;

  pkg_core_min #(.NCORES(NCORES)) u_min (
    .core_states (core_states),
    .shallowest  (shallowest)
  );

  pkg_depth_cap u_cap (
    .shallowest  (shallowest),
    .plat_grant  (plat_grant),
    .depth_limit (depth_limit),
    .target      (target)
  );

  assign want_low = (target == CS_C1) && c1e_en;

  pkg_opp_seq #(
    .RATIO_W   (RATIO_W),
    .VID_W     (VID_W),
    .LOW_RATIO (LOW_RATIO),
    .LOW_VID   (LOW_VID)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .want_low  (want_low),
    .nom_ratio (nom_ratio),
    .nom_vid   (nom_vid),
    .ratio_ack (ratio_ack),
    .vid_ack   (vid_ack),
    .ratio_req (ratio_req),
    .vid_req   (vid_req),
    .busy      (busy),
    .at_low    (at_low)
  );

  // commit only from an idle sequencer already at the right operating point
  assign commit  = !busy && (at_low == want_low);
  assign state_d = commit ? target : state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CS_C0;
    else        state_q <= state_d;
  end

  assign pkg_state = state_q;

  // R7: no state change while a step is pending
  a_r7_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(pkg_state));

  // R2: platform veto forces C0 from the nominal point
  a_r2_veto_c0: assert property (@(posedge clk) disable iff (!rst_n)
    (!plat_grant && !busy && !at_low) |=> (pkg_state == CS_C0));

  // R4: limit 00 never lets the package past C1
  a_r4_cap_c1: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_limit == 2'b00 && !c1e_en && !busy && !at_low) |=> (pkg_state <= CS_C1));

  // R8: without the enable the sequencer never leaves the nominal point
  a_r8_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!c1e_en && !busy && !at_low) |=> !busy);
endmodule

// File: tb/pkg_idle_resolver_test.sv
`timescale 1ns/1ps
module pkg_idle_resolver_test;
  localparam int NC = 4;
  localparam logic [5:0] LR = 6'd8;
  localparam logic [7:0] LV = 8'h20;

  logic clk, rst_n;
  logic [2*NC-1:0] core_states;
  logic plat_grant, c1e_en, ratio_ack, vid_ack;
  logic [1:0] depth_limit;
  logic [5:0] nom_ratio;
  logic [7:0] nom_vid;
  logic [1:0] pkg_state;
  logic [5:0] ratio_req;
  logic [7:0] vid_req;
  logic busy;

  int tests = 0, fails = 0, order_fails = 0;
  bit done = 0;

  pkg_idle_resolver #(.NCORES(NC), .RATIO_W(6), .VID_W(8), .LOW_RATIO(LR), .LOW_VID(LV)) uut (
    .clk(clk), .rst_n(rst_n), .core_states(core_states), .plat_grant(plat_grant),
    .depth_limit(depth_limit), .c1e_en(c1e_en), .nom_ratio(nom_ratio), .nom_vid(nom_vid),
    .ratio_ack(ratio_ack), .vid_ack(vid_ack), .pkg_state(pkg_state),
    .ratio_req(ratio_req), .vid_req(vid_req), .busy(busy));

  initial clk = 0;
  always #2 clk = ~clk;

  function automatic logic [1:0] exp_state(input logic [2*NC-1:0] cs, input logic g,
                                           input logic [1:0] lim);
    logic [1:0] m, cap;
    m = 2'b11;
    for (int i = 0; i < NC; i++) if (cs[2*i +: 2] < m) m = cs[2*i +: 2];
    cap = lim[1] ? 2'b11 : (lim[0] ? 2'b10 : 2'b01);
    if (m == 2'b00 || !g) return 2'b00;
    return (m > cap) ? cap : m;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R5 ordering monitor: low voltage only ever appears with low ratio
  always @(negedge clk) if (rst_n && vid_req == LV && ratio_req != LR) begin
    order_fails++;
    $display("FAIL R5 order: ratio %0h with vid %0h, expected ratio %0h", ratio_req, vid_req, LR);
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0] e;
    void'($urandom(32'd4242));
    rst_n = 0; core_states = '0; plat_grant = 1; depth_limit = 2'b11; c1e_en = 1;
    ratio_ack = 1; vid_ack = 1; nom_ratio = 6'd30; nom_vid = 8'h60;
    cyc(3);
    chk("R1", "reset pkg_state", pkg_state, 0);
    chk("R1", "reset busy", busy, 0);
    rst_n = 1;
    cyc(3);
    chk("R9", "ratio follows nominal", ratio_req, 30);
    chk("R9", "vid follows nominal", vid_req, 8'h60);

    // directed: enhanced C1 entry with manual acknowledges
    ratio_ack = 0; vid_ack = 0;
    core_states = {NC{2'b01}};
    cyc(1);
    chk("R5", "ratio drops first", ratio_req, LR);
    chk("R5", "vid still nominal", vid_req, 8'h60);
    chk("R7", "busy during ratio step", busy, 1);
    chk("R7", "state held during ramp", pkg_state, 0);
    vid_ack = 1; cyc(1); vid_ack = 0;
    chk("R6", "stray vid_ack ignored", vid_req, 8'h60);
    cyc(2);
    chk("R5", "still waiting ratio ack", vid_req, 8'h60);
    ratio_ack = 1; cyc(1); ratio_ack = 0;
    chk("R5", "vid drops after ratio ack", vid_req, LV);
    chk("R7", "state held before vid ack", pkg_state, 0);
    vid_ack = 1; cyc(1); vid_ack = 0;
    chk("R7", "idle at low point", busy, 0);
    cyc(1);
    chk("R7", "C1 committed after ramp", pkg_state, 1);

    // directed: exit
    core_states[1:0] = 2'b00;
    cyc(1);
    chk("R6", "vid restored first", vid_req, 8'h60);
    chk("R6", "ratio still low", ratio_req, LR);
    ratio_ack = 1; cyc(1); ratio_ack = 0;
    chk("R6", "early ratio ack ignored", ratio_req, LR);
    chk("R7", "state held during exit", pkg_state, 1);
    vid_ack = 1; cyc(1); vid_ack = 0;
    chk("R6", "ratio restored after vid ack", ratio_req, 30);
    ratio_ack = 1; cyc(1);
    vid_ack = 1;
    cyc(1);
    chk("R2", "C0 after exit", pkg_state, 0);
    chk("R7", "busy clear after exit", busy, 0);

    // directed: depth cap with all cores in C6
    core_states = {NC{2'b11}};
    depth_limit = 2'b01; cyc(2);
    chk("R4", "limit 01 caps at C3", pkg_state, 2);
    depth_limit = 2'b10; cyc(2);
    chk("R4", "limit 10 allows C6", pkg_state, 3);
    chk("R3", "all C6 gives C6", pkg_state, 3);
    plat_grant = 0; cyc(2);
    chk("R2", "platform veto", pkg_state, 0);
    plat_grant = 1; c1e_en = 0; depth_limit = 2'b00; cyc(1);
    chk("R8", "C1 without enhance in one cycle", pkg_state, 1);
    chk("R8", "no ratio change", ratio_req, 30);
    chk("R8", "not busy", busy, 0);
    core_states = {2'b11, 2'b10, 2'b11, 2'b10}; depth_limit = 2'b11; cyc(2);
    chk("R3", "shallowest of C3/C6", pkg_state, 2);

    // constrained random
    for (int v = 0; v < 300; v++) begin
      for (int i = 0; i < NC; i++) core_states[2*i +: 2] = 2'($urandom % 4);
      if ($urandom % 3 == 0) core_states = {NC{2'(1 + $urandom % 3)}};
      plat_grant  = ($urandom % 5) != 0;
      depth_limit = 2'($urandom % 4);
      c1e_en      = 1'($urandom % 2);
      nom_ratio   = 6'(20 + $urandom % 30);
      nom_vid     = 8'(8'h50 + $urandom % 96);
      cyc(8);
      e = exp_state(core_states, plat_grant, depth_limit);
      chk(e == 0 ? "R2" : "R3", "random pkg_state", pkg_state, e);
      chk("R7", "random busy", busy, 0);
      if (e == 2'b01 && c1e_en) begin
        chk("R5", "random low ratio", ratio_req, LR);
        chk("R5", "random low vid", vid_req, LV);
      end else begin
        chk("R9", "random nominal ratio", ratio_req, nom_ratio);
        chk("R9", "random nominal vid", vid_req, nom_vid);
      end
    end

    tests++;
    if (order_fails != 0) fails++;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule